// File: doc/BRIEF.md
# Flow-Through Burst SRAM Model

A synthesizable model of a small synchronous burst SRAM with a flow-through read path. It serves as a memory target in simulation. The data path is 32 bits wide, split into four byte lanes. Each clock cycle is defined by the controls and address sampled on its opening rising edge. Read data for that cycle's address appears combinationally in the same period. Write data is taken on the closing edge of the cycle and stored at that cycle's address.

There are two address strobes. The processor-side strobe only counts when the master enable is active. The controller-side strobe loads an address whatever the master enable does. A two-bit burst counter steps on an advance input and forms four-beat bursts. The burst follows either an interleaved or a linear order, picked by a static pin. The write controls have layers: a global write, a byte-write gate and per-lane enables.

Output drive is gated by an asynchronous output enable. A snooze pin freezes the device and keeps the contents. After snooze ends, a recovery window drops any write attempt and flags it on a debug pin.

Top module: `fts_burst_ram`

## Requirements
- R1: After reset the data outputs are not driven (`dq_oe`=0) and `wake_drop_o` is 0.
- R2: A low `strobe_ctl_n` loads `addr_i` at the rising edge, even when `cs_main_n` is high.
- R3: A low `strobe_cpu_n` loads `addr_i` only while `cs_main_n` is low. Otherwise it leaves the current address and output unchanged.
- R4: A load selects the device only when `cs_hi`=1 and `cs_lo_n`=0. A load with either enable inactive deselects it, so `dq_oe` stays 0.
- R5: With `burst_ilv`=1, the beats of a burst use word offset start XOR k, k=0..3. Offset k advances on each edge with `adv_n` low.
- R6: With `burst_ilv`=0, the beats use word offset (start+k) mod 4, wrapping within the aligned group of four words.
- R7: With `wr_all_n` low in a selected cycle, all four lanes of that cycle's word take `dq_i` at the closing edge.
- R8: With `wr_all_n` high and `wr_byte_n` low, only lanes whose `lane_we_n` bit is 0 are written. Lane i is bits 8i+7..8i.
- R9: A cycle with `wr_all_n` high and either `wr_byte_n` high or all `lane_we_n` bits high is a read. It drives data and changes no memory.
- R10: `dq_oe` is 1 only in a selected read cycle with `oe_n` low. `oe_n` acts without a clock edge.
- R11: While `sleep_i` is high, `dq_oe` is 0 at once, every other input is ignored and memory keeps its contents.
- R12: For WAKE_CYC edges after `sleep_i` falls, write attempts are dropped and `wake_drop_o` pulses for one cycle. Writes work again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr_i | input | ADDR_W | Word address |
| cs_main_n | input | 1 | Master enable, active low |
| cs_hi | input | 1 | Secondary enable, active high |
| cs_lo_n | input | 1 | Secondary enable, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write gate, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Asynchronous snooze request, active high |
| dq_i | input | 8*LANES | Write data |
| dq_o | output | 8*LANES | Read data, zero when not driven |
| dq_oe | output | 1 | Data drive enable; 0 means high impedance |
| wake_drop_o | output | 1 | Debug pulse: write dropped during wake recovery |

## Verification
A corrupt burst counter or base register appears at once as a wrong word on `dq_o`. The read path has no register, so the error shows in the same cycle as the faulty edge. A wrong write mask or cycle type leaves no trace until that word is read again, or shows up as `dq_oe` being asserted during a write cycle. A wrong snooze or recovery counter shows as a missing or misplaced `wake_drop_o` pulse one edge after the attempt, or as a stored value that should have stayed unchanged.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int unsigned LANE_W = 8;

    typedef logic [1:0] beat_t;

    // word offset of beat cnt in a four-beat burst starting at start
    function automatic beat_t beat_offset(beat_t start, beat_t cnt, logic interleave);
        beat_t lin;
        lin = beat_t'(start + cnt);
        return interleave ? (start ^ cnt) : lin;
    endfunction
endpackage

// File: rtl/fts_wr_decode.sv
module fts_wr_decode #(
    parameter int unsigned LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] mask
);
    always_comb begin
        if (!wr_all_n)       mask = '1;
        else if (!wr_byte_n) mask = ~lane_we_n;
        else                 mask = '0;
    end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-3:0] base,
    input  fts_pkg::beat_t    start,
    input  fts_pkg::beat_t    cnt,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr
);
    assign addr = {base, fts_pkg::beat_offset(start, cnt, interleave)};
endmodule

// File: rtl/fts_store.sv
module fts_store #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4
) (
    input  logic                             clk,
    input  logic [LANES-1:0]                 we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [LANES*fts_pkg::LANE_W-1:0] wdata,
    output logic [LANES*fts_pkg::LANE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned LW    = fts_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) cells[addr] <= wdata[g*LW +: LW];
        end
        assign rdata[g*LW +: LW] = cells[addr];
    end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned LANES    = 4,
    parameter int unsigned WAKE_CYC = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic                             cs_main_n,
    input  logic                             cs_hi,
    input  logic                             cs_lo_n,
    input  logic                             strobe_cpu_n,
    input  logic                             strobe_ctl_n,
    input  logic                             adv_n,
    input  logic                             wr_all_n,
    input  logic                             wr_byte_n,
    input  logic [LANES-1:0]                 lane_we_n,
    input  logic                             oe_n,
    input  logic                             burst_ilv,
    input  logic                             sleep_i,
    input  logic [LANES*fts_pkg::LANE_W-1:0] dq_i,
    output logic [LANES*fts_pkg::LANE_W-1:0] dq_o,
    output logic                             dq_oe,
    output logic                             wake_drop_o
);
    import fts_pkg::*;

    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-3:0] base;
        beat_t             start;
        beat_t             cnt;
        logic [LANES-1:0]  mask;
        logic [WAKE_W-1:0] wake;
        logic              drop;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]  req_mask;
    logic [LANES-1:0]  store_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_word;
    logic              cpu_take, ctl_take, sel_ok, drive;

    fts_wr_decode #(.LANES(LANES)) u_dec (
        .wr_all_n (wr_all_n),
        .wr_byte_n(wr_byte_n),
        .lane_we_n(lane_we_n),
        .mask     (req_mask)
    );

    fts_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base      (st_q.base),
        .start     (st_q.start),
        .cnt       (st_q.cnt),
        .interleave(burst_ilv),
        .addr      (cur_addr)
    );

    assign store_we = (st_q.active && !sleep_i) ? st_q.mask : '0;

    fts_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
        .clk  (clk),
        .we   (store_we),
        .addr (cur_addr),
        .wdata(dq_i),
        .rdata(rd_word)
    );

    assign cpu_take = !strobe_cpu_n && !cs_main_n;
    assign ctl_take = !strobe_ctl_n;
    assign sel_ok   = cs_hi && !cs_lo_n;

    always_comb begin
        st_d      = st_q;
        st_d.drop = 1'b0;
        if (sleep_i) begin
            st_d.active = 1'b0;
            st_d.mask   = '0;
            st_d.wake   = WAKE_W'(WAKE_CYC);
        end else begin
            if (cpu_take || ctl_take) begin
                st_d.active = sel_ok;
                st_d.base   = addr_i[ADDR_W-1:2];
                st_d.start  = addr_i[1:0];
                st_d.cnt    = '0;
            end else if (!adv_n && st_q.active) begin
                st_d.cnt = beat_t'(st_q.cnt + 2'd1);
            end
            st_d.mask = '0;
            if (st_d.active && (req_mask != '0)) begin
                if (st_q.wake != '0) st_d.drop = 1'b1;
                else                 st_d.mask = req_mask;
            end
            if (st_q.wake != '0) st_d.wake = WAKE_W'(st_q.wake - 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive       = st_q.active && (st_q.mask == '0) && !oe_n && !sleep_i;
    assign dq_oe       = drive;
    assign dq_o        = drive ? rd_word : '0;
    assign wake_drop_o = st_q.drop;
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              strobe_ctl_n,
    input logic              strobe_cpu_n,
    input logic              cs_main_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_all_n,
    input logic              wr_byte_n,
    input logic [LANES-1:0]  lane_we_n,
    input logic              dq_oe,
    input logic              wake_drop_o,
    input logic [ADDR_W-1:0] cur_addr
);
    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && !sleep_i) |=> (cur_addr == $past(addr_i)));

    // R3
    cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl_n && !strobe_cpu_n && cs_main_n && adv_n && !sleep_i) |=> $stable(cur_addr));

    // R5
    burst_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl_n && (strobe_cpu_n || cs_main_n) && !sleep_i) |=> $stable(cur_addr[ADDR_W-1:2]));

    // R12
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_drop_o |-> $past(!wr_all_n || (!wr_byte_n && (lane_we_n != '1))));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_i) |-> !wake_drop_o);

    // R11
    sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !dq_oe);
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .strobe_ctl_n(strobe_ctl_n),
    .strobe_cpu_n(strobe_cpu_n),
    .cs_main_n   (cs_main_n),
    .adv_n       (adv_n),
    .addr_i      (addr_i),
    .wr_all_n    (wr_all_n),
    .wr_byte_n   (wr_byte_n),
    .lane_we_n   (lane_we_n),
    .dq_oe       (dq_oe),
    .wake_drop_o (wake_drop_o),
    .cur_addr    (cur_addr)
);

// File: tb/sim_fts_burst_ram.sv
`timescale 1ns/1ps
module sim_fts_burst_ram;
    localparam int unsigned AW   = 8;
    localparam int unsigned WAKE = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          cs_main_n, cs_hi, cs_lo_n;
    logic          strobe_cpu_n, strobe_ctl_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    lane_we_n;
    logic          oe_n, burst_ilv, sleep_i;
    logic [31:0]   dq_i, dq_o;
    logic          dq_oe, wake_drop_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fts_burst_ram #(.ADDR_W(AW), .LANES(4), .WAKE_CYC(WAKE)) u0 (.*);

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h20, 32'hA0A0_0000},
        '{1'b1, 8'h21, 32'hA1A1_1111},
        '{1'b1, 8'h22, 32'hA2A2_2222},
        '{1'b1, 8'h23, 32'hA3A3_3333},
        '{1'b0, 8'h23, 32'hA3A3_3333},
        '{1'b0, 8'h20, 32'hA0A0_0000},
        '{1'b0, 8'h22, 32'hA2A2_2222},
        '{1'b0, 8'h21, 32'hA1A1_1111}
    };

    function automatic logic [31:0] word_at(int off);
        return VECS[off].d;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        addr_i = '0; cs_main_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_we_n = 4'hF; oe_n = 1'b1;
    endtask

    task automatic wr_word(logic [7:0] a, logic [31:0] d);
        idle; strobe_ctl_n = 1'b0; addr_i = a; wr_all_n = 1'b0;
        tick;
        idle; dq_i = d;
        tick;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        idle; strobe_ctl_n = 1'b0; addr_i = a;
        tick;
        idle; oe_n = 1'b0;
        #1;
        chk(tag, {31'd0, dq_oe}, 32'd1);
        chk(tag, dq_o, exp);
    endtask

    task automatic burst_chk(string tag, logic [7:0] a, logic ilv);
        burst_ilv = ilv;
        rd_chk(tag, a, word_at(int'(a[1:0])));
        for (int k = 1; k < 4; k++) begin
            int off;
            off = ilv ? (int'(a[1:0]) ^ k) : ((int'(a[1:0]) + k) % 4);
            adv_n = 1'b0;
            tick;
            chk(tag, dq_o, word_at(off));
        end
        adv_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle; burst_ilv = 1'b1; sleep_i = 1'b0; dq_i = '0; rst_n = 1'b0;
        tick; tick;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 oe", {31'd0, dq_oe}, 32'd0);
        chk("R1 drop", {31'd0, wake_drop_o}, 32'd0);

        // R7 global writes and readback through the vector table
        foreach (VECS[i]) begin
            if (VECS[i].wr) wr_word(VECS[i].a, VECS[i].d);
            else            rd_chk("R7 table", VECS[i].a, VECS[i].d);
        end

        // R5 interleaved bursts
        burst_chk("R5 ilv s2", 8'h22, 1'b1);
        burst_chk("R5 ilv s1", 8'h21, 1'b1);
        // R6 linear bursts with wrap
        burst_chk("R6 lin s3", 8'h23, 1'b0);
        burst_chk("R6 lin s1", 8'h21, 1'b0);
        burst_ilv = 1'b1;

        // R2 controller strobe loads with master enable inactive
        idle; cs_main_n = 1'b1; strobe_ctl_n = 1'b0; addr_i = 8'h21;
        tick;
        idle; oe_n = 1'b0; #1;
        chk("R2 ctl load", dq_o, VECS[1].d);

        // R3 processor strobe ignored while master enable inactive
        cs_main_n = 1'b1; strobe_cpu_n = 1'b0; addr_i = 8'h23;
        tick;
        chk("R3 ignored", dq_o, VECS[1].d);
        cs_main_n = 1'b0;
        tick;
        strobe_cpu_n = 1'b1; #1;
        chk("R3 accepted", dq_o, VECS[3].d);

        // R10 asynchronous output enable
        oe_n = 1'b1; #1;
        chk("R10 off", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R10 on", {31'd0, dq_oe}, 32'd1);

        // R4 secondary enables deselect
        idle; strobe_ctl_n = 1'b0; addr_i = 8'h20; cs_hi = 1'b0;
        tick;
        idle; oe_n = 1'b0; #1;
        chk("R4 cs_hi low", {31'd0, dq_oe}, 32'd0);
        strobe_ctl_n = 1'b0; cs_lo_n = 1'b1;
        tick;
        idle; oe_n = 1'b0; #1;
        chk("R4 cs_lo_n high", {31'd0, dq_oe}, 32'd0);

        // R8 per-lane write: lanes 0 and 2 enabled
        wr_word(8'h30, 32'h1122_3344);
        idle; strobe_ctl_n = 1'b0; addr_i = 8'h30; wr_byte_n = 1'b0; lane_we_n = 4'b1010;
        tick;
        idle; dq_i = 32'hAABB_CCDD;
        tick;
        rd_chk("R8 lanes", 8'h30, 32'h11BB_33DD);

        // R9 byte gate high makes the cycle a read
        idle; strobe_ctl_n = 1'b0; addr_i = 8'h30; wr_byte_n = 1'b1; lane_we_n = 4'h0;
        tick;
        strobe_ctl_n = 1'b1; oe_n = 1'b0; dq_i = 32'h0; #1;
        chk("R9 drives", {31'd0, dq_oe}, 32'd1);
        chk("R9 data", dq_o, 32'h11BB_33DD);
        tick;
        rd_chk("R9 unchanged", 8'h30, 32'h11BB_33DD);

        // R11 snooze
        sleep_i = 1'b1; #1;
        chk("R11 hiz", {31'd0, dq_oe}, 32'd0);
        tick;
        strobe_ctl_n = 1'b0; addr_i = 8'h20; wr_all_n = 1'b0; dq_i = 32'hDEAD_BEEF;
        tick;
        idle;
        tick;
        sleep_i = 1'b0;

        // R12 recovery window drops writes
        strobe_ctl_n = 1'b0; addr_i = 8'h21; wr_all_n = 1'b0;
        tick;
        chk("R12 drop flag", {31'd0, wake_drop_o}, 32'd1);
        idle; dq_i = 32'hBAD0_BAD0;
        tick;
        chk("R12 flag clears", {31'd0, wake_drop_o}, 32'd0);
        tick; tick;
        wr_word(8'h22, 32'h5555_AAAA);
        rd_chk("R11 retained", 8'h20, VECS[0].d);
        rd_chk("R12 dropped", 8'h21, VECS[1].d);
        rd_chk("R12 accepted", 8'h22, 32'h5555_AAAA);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule